// File: doc/BRIEF.md
# Schedule Run/Stop Debug Controller

This block governs whether a frame-based host controller walks its descriptor command list. Software drives two command bits: one that asks the schedule to run and one that puts it in debug mode. The datapath around the block sends pulses when a descriptor is fetched, when the command it holds completes, and when a fatal consistency error is found, for example an illegal packet ID in a descriptor header. The block decides when execution really stops. It keeps the frame timer and the frame index, and it tracks a cursor into the command list. It also keeps a 16-bit status word whose bits are cleared by writing 1.

A stop never cuts a command short. Execution drains the current descriptor first. With debug off, a stop rewinds the frame timer and the list cursor, so the next run starts at the beginning of the frame chosen by the current frame index. With debug on, a stop freezes both the timer and the cursor, so the next run resumes in place. In debug mode the block also clears the run bit itself at every accepted fetch, which gives single stepping. A fatal error records a process-error flag, drops the run bit and raises a one-cycle system reset request.

Top module: `sched_runctl`

## Requirements
- R1: After reset the run and debug bits are 0, the controller is not running and no command is executing. The frame index, frame timer, list cursor and status word are all 0, and the reset request is low.
- R2: If the run bit is cleared while a command is executing, the controller keeps running until that command completes. Once nothing is executing and the run bit is 0, the controller stops one cycle later.
- R3: A stop with the debug bit at 0 sets the frame timer and the list cursor to 0. The frame index keeps its value.
- R4: A frame index write takes effect only while the run bit is 0. A write made while the run bit is 1 leaves the index unchanged.
- R5: A stop with the debug bit at 1 holds the frame timer and the list cursor at their values. A later restart continues from those values.
- R6: While the debug bit is 1, an accepted descriptor fetch clears the run bit in the same cycle. The controller then stops once that descriptor completes.
- R7: Status bit 5 (halted) sets in the cycle the controller stops. It clears in the cycle the controller starts again.
- R8: A fatal error pulse clears the run bit, aborts the executing command and sets status bit 4. In the next cycle it drives a one-cycle reset request. It overrides a software write that sets the run bit in the same cycle.
- R9: The status word reads 0 in bits 15:6 and 3:0. Writing 1 to bit 4 or bit 5 clears it, and writing 0 leaves it unchanged. A hardware set in the same cycle as a clear leaves the bit at 1.
- R10: The frame timer counts tick pulses only while the controller is running. After FRAME_TICKS ticks it wraps to 0, the frame index increments modulo 2^FNUM_W and the list cursor returns to 0.
- R11: A descriptor fetch is accepted only when the controller is running, the run bit is 1 and no command is executing. Each accepted fetch starts execution and increments the list cursor. A completion pulse ends execution, and a completion pulse with nothing executing does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_run_wdata | input | 1 | Run bit value to write |
| cmd_dbg_wdata | input | 1 | Debug bit value to write |
| fnum_wr | input | 1 | Frame index write strobe |
| fnum_wdata | input | FNUM_W | Frame index value to write |
| sts_wr | input | 1 | Status write strobe (write 1 to clear) |
| sts_wdata | input | 16 | Status write data |
| tick | input | 1 | Frame timer advance pulse |
| td_fetch | input | 1 | Descriptor fetch pulse |
| cmd_done | input | 1 | Command completion pulse |
| fatal_err | input | 1 | Fatal consistency error pulse |
| run_bit | output | 1 | Current run bit |
| dbg_bit | output | 1 | Current debug bit |
| hc_running | output | 1 | Controller is executing the schedule |
| executing | output | 1 | A descriptor command is in progress |
| frame_num | output | FNUM_W | Frame index |
| frame_timer | output | TIMER_W | Position inside the current frame |
| list_pos | output | POS_W | Command list cursor within the frame |
| status | output | 16 | Status word |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The hardest situation to reach is a hardware set of the halted bit that falls in the same cycle as a software clear of that bit. It needs a stop whose timing is exact to the cycle. The bench uses a debug-mode single step to make one. The accepted fetch clears the run bit, and the completion pulse then puts the stop cycle at a known clock edge, where the bench drives a clear of the halted bit. A fatal error is likewise made to coincide with a write that sets the run bit and with a clear of the process-error bit.

// File: rtl/sched_runctl.sv
module sched_runctl #(
  parameter int FRAME_TICKS = 1000,
  parameter int FNUM_W      = 11,
  parameter int POS_W       = 8,
  localparam int TIMER_W    = (FRAME_TICKS > 1) ? $clog2(FRAME_TICKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_run_wdata,
  input  logic              cmd_dbg_wdata,
  input  logic              fnum_wr,
  input  logic [FNUM_W-1:0] fnum_wdata,
  input  logic              sts_wr,
  input  logic [15:0]       sts_wdata,
  input  logic              tick,
  input  logic              td_fetch,
  input  logic              cmd_done,
  input  logic              fatal_err,
  output logic              run_bit,
  output logic              dbg_bit,
  output logic              hc_running,
  output logic              executing,
  output logic [FNUM_W-1:0] frame_num,
  output logic [TIMER_W-1:0] frame_timer,
  output logic [POS_W-1:0]  list_pos,
  output logic [15:0]       status,
  output logic              sys_reset_req
);
  localparam logic [15:0] STS_MASK = 16'h0030;
  localparam logic [15:0] HALT_BIT = 16'h0020;
  localparam logic [15:0] PERR_BIT = 16'h0010;
  localparam logic [TIMER_W-1:0] TIMER_LAST = TIMER_W'(FRAME_TICKS - 1);

  logic accept_fetch, stop_evt, start_evt, wrap;
  logic [15:0] hw_set, hw_clr, sw_clr;

  assign accept_fetch = td_fetch & hc_running & run_bit & ~executing & ~fatal_err;
  assign stop_evt     = hc_running & ~run_bit & ~executing;
  assign start_evt    = ~hc_running & run_bit;
  assign wrap         = hc_running & tick & (frame_timer == TIMER_LAST);

  assign hw_set = (stop_evt ? HALT_BIT : 16'h0) | (fatal_err ? PERR_BIT : 16'h0);
  assign hw_clr = start_evt ? HALT_BIT : 16'h0;
  assign sw_clr = sts_wr ? sts_wdata : 16'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_bit <= 1'b0;
      dbg_bit <= 1'b0;
    end else begin
      if (fatal_err)
        run_bit <= 1'b0;
      else if (cmd_wr)
        run_bit <= cmd_run_wdata;
      else if (accept_fetch && dbg_bit)
        run_bit <= 1'b0;
      if (cmd_wr)
        dbg_bit <= cmd_dbg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc_running <= 1'b0;
      executing  <= 1'b0;
    end else begin
      if (start_evt)
        hc_running <= 1'b1;
      else if (stop_evt)
        hc_running <= 1'b0;
      if (fatal_err)
        executing <= 1'b0;
      else if (accept_fetch)
        executing <= 1'b1;
      else if (cmd_done)
        executing <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_timer <= '0;
      list_pos    <= '0;
      frame_num   <= '0;
    end else begin
      if (stop_evt && !dbg_bit)
        frame_timer <= '0;
      else if (hc_running && tick)
        frame_timer <= wrap ? '0 : frame_timer + 1'b1;

      if (stop_evt && !dbg_bit)
        list_pos <= '0;
      else if (wrap)
        list_pos <= accept_fetch ? POS_W'(1) : '0;
      else if (accept_fetch)
        list_pos <= list_pos + 1'b1;

      if (fnum_wr && !run_bit)
        frame_num <= fnum_wdata;
      else if (wrap)
        frame_num <= frame_num + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status        <= 16'h0000;
      sys_reset_req <= 1'b0;
    end else begin
      status        <= (((status & ~sw_clr) | hw_set) & ~hw_clr) & STS_MASK;
      sys_reset_req <= fatal_err;
    end
  end
endmodule

// File: rtl/sched_runctl_chk.sv
module sched_runctl_chk #(
  parameter int FNUM_W  = 11,
  parameter int TIMER_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr,
  input logic              td_fetch,
  input logic              cmd_done,
  input logic              fatal_err,
  input logic              run_bit,
  input logic              dbg_bit,
  input logic              hc_running,
  input logic              executing,
  input logic [FNUM_W-1:0] frame_num,
  input logic [TIMER_W-1:0] frame_timer,
  input logic [15:0]       status,
  input logic              sys_reset_req
);
  p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (executing && !cmd_done && !fatal_err) |=> hc_running);

  p_fnum_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_bit && !hc_running) |=> $stable(frame_num));

  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_bit && td_fetch && hc_running && run_bit && !executing && !cmd_wr && !fatal_err)
      |=> (!run_bit && executing));

  p_halt_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hc_running) |-> status[5]);

  p_halt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hc_running) |-> !status[5]);

  p_fatal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |=> (!run_bit && !executing && status[4] && sys_reset_req));

  p_timer_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hc_running |=> $stable(frame_timer));
endmodule

bind sched_runctl sched_runctl_chk #(.FNUM_W(FNUM_W), .TIMER_W(TIMER_W)) u_chk (.*);

// File: tb/sched_runctl_test.sv
module sched_runctl_test;
  localparam int FT = 4;
  localparam int FW = 4;
  localparam int PW = 4;
  localparam int TW = 2;

  logic clk = 0, rst_n = 0;
  logic cmd_wr = 0, cmd_run_wdata = 0, cmd_dbg_wdata = 0;
  logic fnum_wr = 0; logic [FW-1:0] fnum_wdata = '0;
  logic sts_wr = 0; logic [15:0] sts_wdata = '0;
  logic tick = 0, td_fetch = 0, cmd_done = 0, fatal_err = 0;
  logic run_bit, dbg_bit, hc_running, executing, sys_reset_req;
  logic [FW-1:0] frame_num; logic [TW-1:0] frame_timer; logic [PW-1:0] list_pos;
  logic [15:0] status;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sched_runctl #(.FRAME_TICKS(FT), .FNUM_W(FW), .POS_W(PW)) uut (.*);

  task automatic step(); @(posedge clk); #1; endtask
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask
  task automatic cmd(logic r, logic d);
    cmd_wr = 1; cmd_run_wdata = r; cmd_dbg_wdata = d; step(); cmd_wr = 0;
  endtask
  task automatic pulse_tick(); tick = 1; step(); tick = 0; endtask
  task automatic fetch(); td_fetch = 1; step(); td_fetch = 0; endtask
  task automatic finish_cmd(); cmd_done = 1; step(); cmd_done = 0; endtask
  task automatic w1c(logic [15:0] v); sts_wr = 1; sts_wdata = v; step(); sts_wr = 0; endtask
  task automatic wr_fnum(logic [FW-1:0] v); fnum_wr = 1; fnum_wdata = v; step(); fnum_wr = 0; endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    chk("R1 run", run_bit, 0); chk("R1 running", hc_running, 0);
    chk("R1 status", status, 16'h0000); chk("R1 frame", frame_num, 0);
    chk("R1 timer", frame_timer, 0); chk("R1 cursor", list_pos, 0);
    chk("R1 rstreq", sys_reset_req, 0);

    wr_fnum(4'd5); chk("R4 write stopped", frame_num, 5);
    cmd(1, 0); step(); chk("R7 running", hc_running, 1); chk("R7 halt clear", status[5], 0);
    wr_fnum(4'd9); chk("R4 write ignored", frame_num, 5);

    for (int n = 1; n <= 10; n++) begin
      pulse_tick();
      chk("R10 timer", frame_timer, n % FT);
      chk("R10 frame", frame_num, (5 + n / FT) % 16);
    end

    finish_cmd(); chk("R11 stray done", executing, 0);
    fetch(); chk("R11 exec", executing, 1); chk("R11 cursor", list_pos, 1);
    fetch(); chk("R11 fetch while exec", list_pos, 1);
    finish_cmd(); chk("R11 done", executing, 0);
    fetch(); chk("R11 second", list_pos, 2);

    cmd(0, 0); step(); step();
    chk("R2 draining", hc_running, 1); chk("R2 no halt yet", status[5], 0);
    finish_cmd(); chk("R2 still running", hc_running, 1);
    step();
    chk("R7 halted", status, 16'h0020); chk("R2 stopped", hc_running, 0);
    chk("R3 timer reset", frame_timer, 0); chk("R3 cursor reset", list_pos, 0);
    chk("R3 frame kept", frame_num, 7);
    pulse_tick(); pulse_tick(); chk("R10 no count stopped", frame_timer, 0);

    w1c(16'h0000); chk("R9 write 0", status, 16'h0020);
    w1c(16'h0020); chk("R9 w1c", status, 16'h0000);

    cmd(1, 0); step(); chk("R3 restart", hc_running, 1);
    chk("R3 sof timer", frame_timer, 0); chk("R3 sof cursor", list_pos, 0);
    pulse_tick(); fetch(); finish_cmd();
    cmd(0, 1); step();
    chk("R5 stopped", hc_running, 0); chk("R5 timer frozen", frame_timer, 1);
    chk("R5 cursor frozen", list_pos, 1);
    pulse_tick(); chk("R5 no count", frame_timer, 1);
    w1c(16'h0020);
    cmd(1, 1); step(); chk("R5 resume", hc_running, 1);
    chk("R5 resume timer", frame_timer, 1); chk("R5 resume cursor", list_pos, 1);

    fetch(); chk("R6 run cleared", run_bit, 0); chk("R6 exec", executing, 1);
    chk("R6 cursor", list_pos, 2);
    step(); chk("R6 drain", hc_running, 1);
    finish_cmd(); step(); chk("R6 halted", status, 16'h0020); chk("R6 stopped", hc_running, 0);
    chk("R6 cursor kept", list_pos, 2);

    cmd(1, 1); step(); chk("R7 restart clear", status, 16'h0000);
    fetch(); finish_cmd();
    sts_wr = 1; sts_wdata = 16'h0020; step(); sts_wr = 0;
    chk("R9 set beats clear", status, 16'h0020); chk("R9 stop", hc_running, 0);
    w1c(16'h0020);

    cmd(1, 0); step(); fetch();
    fatal_err = 1; cmd_wr = 1; cmd_run_wdata = 1; cmd_dbg_wdata = 0;
    sts_wr = 1; sts_wdata = 16'h0010;
    step();
    fatal_err = 0; cmd_wr = 0; sts_wr = 0;
    chk("R8 run cleared", run_bit, 0); chk("R8 perr", status, 16'h0010);
    chk("R8 rstreq", sys_reset_req, 1); chk("R8 abort", executing, 0);
    step(); chk("R8 rstreq pulse", sys_reset_req, 0);
    chk("R8 halted", status, 16'h0030); chk("R8 stopped", hc_running, 0);
    w1c(16'h0010); chk("R9 clear perr", status, 16'h0020);
    w1c(16'hFFFF); chk("R9 reserved zero", status, 16'h0000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule